// File: doc/BRIEF.md
# Steered-Adder Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for narrow datapaths. It takes two operands, `op_a` and `op_b`, and a four-bit function code. It returns a result word and a carry. Both halves of the unit evaluate in parallel on every input change. The top bit of the function code decides which half drives the result. No clock, reset or storage is involved.

The arithmetic half uses a single ripple-carry adder for all eight of its operations. One adder input is always `op_a`. The carry into the adder is always function bit 0. The other adder input comes from a small per-bit steering stage, controlled by function bits 2 and 1. That stage can supply zeros, `op_b`, the complement of `op_b`, or ones.

The logic half forms a bitwise function of the operands, controlled by function bits 1 and 0. When a logic function is selected, the carry output is held at 0. The width is a parameter and defaults to 4 bits.

Top module: `steered_alu`

## Requirements
- R1: With function code 4'b0000 the result equals `op_a` and `carry_out` is 0.
- R2: With function code 4'b0001 the result is `op_a`+1 modulo 2^W, and `carry_out` is 1 exactly when `op_a` is all ones.
- R3: Function codes 4'b0010 and 4'b0011 give `op_a`+`op_b` and `op_a`+`op_b`+1. `carry_out` is bit W of the full sum.
- R4: Function code 4'b0100 gives `op_a` plus the bitwise complement of `op_b`. Code 4'b0101 gives `op_a`-`op_b` in two's complement, and there `carry_out` is 1 exactly when `op_a` >= `op_b` (unsigned).
- R5: Function code 4'b0110 gives `op_a`-1 modulo 2^W, and `carry_out` is 0 only when `op_a` is zero.
- R6: Function code 4'b0111 returns `op_a` unchanged with `carry_out` equal to 1.
- R7: When function bit 3 is 1, function bits 1:0 choose the result: 00 gives AND, 01 gives OR, 10 gives XOR, 11 gives the complement of `op_a`. Function bit 2 has no effect on the result.
- R8: When function bit 3 is 1, `carry_out` is 0 for all operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand; always one adder input |
| op_b | input | WIDTH | Second operand; steered into the adder or used by logic |
| func_sel | input | 4 | Function code: bit 3 picks logic, bits 2:0 choose the operation |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Adder carry out of the top bit, 0 during logic functions |

## Verification
The corner cases are where the carry behaves in ways that are easy to get wrong.

- **Increment of all ones.** The result wraps to zero with a carry. A carry chain cut one bit short would lose that carry.
- **Decrement of zero.** The result is all ones with no carry. A design that inverted the carry sense would report a carry here.
- **Code 0111.** The adder adds all ones plus one, so it returns the operand with a carry of 1. A design that special-cased this code as a plain transfer would clear the carry.
- **Logic functions.** They are exercised with the steering bit set both ways and with operands that would carry. A design leaking the adder carry or decoding bit 2 would show it.

An exhaustive sweep of every operand and code pair then catches any swapped steering or logic encoding.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Second adder input choice, indexed by function bits 2:1
    typedef enum logic [1:0] {
        STEER_ZERO = 2'b00,
        STEER_PASS = 2'b01,
        STEER_INV  = 2'b10,
        STEER_ONES = 2'b11
    } steer_e;

    // Bitwise function, indexed by function bits 1:0
    typedef enum logic [1:0] {
        BIT_AND  = 2'b00,
        BIT_OR   = 2'b01,
        BIT_XOR  = 2'b10,
        BIT_NOTA = 2'b11
    } bitop_e;

    localparam int FUNC_W = 4;

endpackage

// File: rtl/alu_steer.sv
module alu_steer
    import alu_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit GATE_FORM = 1'b1
) (
    input  logic [WIDTH-1:0] opnd,
    input  steer_e           mode,
    output logic [WIDTH-1:0] steered
);

    if (GATE_FORM) begin : g_gates
        // Sum of products per bit: hi-bit selects complement, lo-bit selects true
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign steered[i] = (mode[1] & ~opnd[i]) | (mode[0] & opnd[i]);
        end
    end else begin : g_mux
        always_comb begin
            unique case (mode)
                STEER_ZERO: steered = '0;
                STEER_PASS: steered = opnd;
                STEER_INV:  steered = ~opnd;
                STEER_ONES: steered = '1;
                default:    steered = '0;
            endcase
        end
    end

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] add_x,
    input  logic [WIDTH-1:0] add_y,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out
);

    logic [WIDTH:0] chain;

    assign chain[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum[i]     = add_x[i] ^ add_y[i] ^ chain[i];
        assign chain[i+1] = (add_x[i] & add_y[i]) | (chain[i] & (add_x[i] ^ add_y[i]));
    end

    assign c_out = chain[WIDTH];

    // Gate-level chain must agree with arithmetic addition (R3)
    always_comb begin
        if (!$isunknown({add_x, add_y, c_in})) begin
            p_ripple_sum_r3: assert ({c_out, sum} ==
                ({1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, c_in}))
                else $error("ripple chain disagrees with arithmetic sum");
        end
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  bitop_e           op,
    output logic [WIDTH-1:0] out
);

    always_comb begin
        unique case (op)
            BIT_AND:  out = lhs & rhs;
            BIT_OR:   out = lhs | rhs;
            BIT_XOR:  out = lhs ^ rhs;
            BIT_NOTA: out = ~lhs;
            default:  out = '0;
        endcase
    end

endmodule

// File: rtl/steered_alu.sv
module steered_alu
    import alu_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit GATE_FORM = 1'b1
) (
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [FUNC_W-1:0] func_sel,
    output logic [WIDTH-1:0]  result,
    output logic              carry_out
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] adder_in;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_cy;
    logic [WIDTH-1:0] logic_out;
    logic             pick_logic;

    assign pick_logic = func_sel[3];

    alu_steer #(.WIDTH(WIDTH), .GATE_FORM(GATE_FORM)) steer_i (
        .opnd    (op_b),
        .mode    (steer_e'(func_sel[2:1])),
        .steered (adder_in)
    );

    alu_ripple #(.WIDTH(WIDTH)) adder_i (
        .add_x (op_a),
        .add_y (adder_in),
        .c_in  (func_sel[0]),
        .sum   (arith_sum),
        .c_out (arith_cy)
    );

    alu_bitwise #(.WIDTH(WIDTH)) bits_i (
        .lhs (op_a),
        .rhs (op_b),
        .op  (bitop_e'(func_sel[1:0])),
        .out (logic_out)
    );

    assign result    = pick_logic ? logic_out : arith_sum;
    assign carry_out = pick_logic ? 1'b0 : arith_cy;

    always_comb begin
        if (!$isunknown({op_a, op_b, func_sel})) begin
            if (func_sel == 4'b0000) begin
                p_transfer_r1: assert (result == op_a && !carry_out)
                    else $error("transfer code altered operand or carried");
            end
            if (func_sel == 4'b0111) begin
                p_wrap_transfer_r6: assert (result == op_a && carry_out)
                    else $error("code 0111 must return operand with carry");
            end
            if (func_sel == 4'b0110 && op_a == '0) begin
                p_dec_zero_r5: assert (result == ALL_ONES && !carry_out)
                    else $error("decrement of zero mishandled");
            end
            if (func_sel[3] && func_sel[1:0] == 2'b11) begin
                p_not_a_r7: assert (result == ~op_a)
                    else $error("complement function wrong");
            end
            if (func_sel[3]) begin
                p_logic_no_carry_r8: assert (!carry_out)
                    else $error("carry leaked during logic function");
            end
        end
    end

endmodule

// File: tb/steered_alu_tb_top.sv
module steered_alu_tb_top;

    localparam int W = 4;
    localparam int NVEC = 16;
    localparam int WATCHDOG_NS = 100000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   func_sel = '0;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    steered_alu #(.WIDTH(W)) dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .func_sel  (func_sel),
        .result    (result),
        .carry_out (carry_out)
    );

    // Vector layout: {a, b, code, expected result, expected carry}
    localparam logic [16:0] VEC [NVEC] = '{
        {4'h5, 4'h3, 4'b0000, 4'h5, 1'b0},  // R1 transfer
        {4'hF, 4'h0, 4'b0001, 4'h0, 1'b1},  // R2 increment wraps
        {4'h7, 4'h0, 4'b0001, 4'h8, 1'b0},  // R2
        {4'h9, 4'h8, 4'b0010, 4'h1, 1'b1},  // R3 add with carry
        {4'h9, 4'h8, 4'b0011, 4'h2, 1'b1},  // R3 add plus one
        {4'h3, 4'h5, 4'b0100, 4'hD, 1'b0},  // R4 ones' complement
        {4'h7, 4'h3, 4'b0101, 4'h4, 1'b1},  // R4 no borrow
        {4'h3, 4'h7, 4'b0101, 4'hC, 1'b0},  // R4 borrow
        {4'h0, 4'h6, 4'b0110, 4'hF, 1'b0},  // R5 decrement of zero
        {4'h6, 4'h0, 4'b0110, 4'h5, 1'b1},  // R5
        {4'hA, 4'h2, 4'b0111, 4'hA, 1'b1},  // R6
        {4'hC, 4'hA, 4'b1000, 4'h8, 1'b0},  // R7 AND
        {4'hC, 4'hA, 4'b1101, 4'hE, 1'b0},  // R7 OR, bit 2 set
        {4'hC, 4'hA, 4'b1010, 4'h6, 1'b0},  // R7 XOR
        {4'hC, 4'hA, 4'b1111, 4'h3, 1'b0},  // R7 NOT, bit 2 set
        {4'hF, 4'hF, 4'b1001, 4'hF, 1'b0}   // R8 operands that would carry
    };

    function automatic string req_of(input logic [3:0] code);
        if (code[3]) return "R7/R8";
        case (code[2:0])
            3'b000:         return "R1";
            3'b001:         return "R2";
            3'b010, 3'b011: return "R3";
            3'b100, 3'b101: return "R4";
            3'b110:         return "R5";
            default:        return "R6";
        endcase
    endfunction

    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [3:0] code);
        logic [W-1:0] second;
        if (code[3]) begin
            case (code[1:0])
                2'b00:   return {1'b0, a & b};
                2'b01:   return {1'b0, a | b};
                2'b10:   return {1'b0, a ^ b};
                default: return {1'b0, ~a};
            endcase
        end
        case (code[2:1])
            2'b00:   second = '0;
            2'b01:   second = b;
            2'b10:   second = ~b;
            default: second = '1;
        endcase
        return {1'b0, a} + {1'b0, second} + {{W{1'b0}}, code[0]};
    endfunction

    task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic [3:0] code, input logic [W-1:0] exp_g,
                               input logic exp_c, input string tag);
        @(posedge clk);
        op_a = a; op_b = b; func_sel = code;
        @(negedge clk);
        checks++;
        if (result !== exp_g || carry_out !== exp_c) begin
            fails++;
            $display("FAIL %s a=%h b=%h code=%b actual=%h/%b expected=%h/%b",
                     tag, a, b, code, result, carry_out, exp_g, exp_c);
        end
    endtask

    initial begin
        // Idle inputs: code 0000 with zero operands (R1)
        @(negedge clk);
        checks++;
        if (result !== '0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle actual=%h/%b expected=0/0", result, carry_out);
        end

        for (int i = 0; i < NVEC; i++) begin
            apply_check(VEC[i][16:13], VEC[i][12:9], VEC[i][8:5], VEC[i][4:1],
                        VEC[i][0], req_of(VEC[i][8:5]));
        end

        // R2 and R5 boundaries; R6 wraps at all-ones operand; R8 with every carry-prone input
        apply_check(4'hE, 4'h0, 4'b0001, 4'hF, 1'b0, "R2");
        apply_check(4'h1, 4'h0, 4'b0110, 4'h0, 1'b1, "R5");
        apply_check(4'hF, 4'h0, 4'b0111, 4'hF, 1'b1, "R6");
        apply_check(4'h5, 4'h5, 4'b0101, 4'h0, 1'b1, "R4");
        apply_check(4'hF, 4'hF, 4'b1100, 4'hF, 1'b0, "R8");

        // Exhaustive sweep of operands and codes against the model (R1 through R8)
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic [W:0] exp;
                    exp = model(W'(a), W'(b), 4'(c));
                    apply_check(W'(a), W'(b), 4'(c), exp[W-1:0], exp[W], req_of(4'(c)));
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule